// File: doc/BRIEF.md
# Single-Shot Sample-and-Convert Sequencer

The block sequences one sample-and-convert operation for a single analog channel. A start arrives either from a software start pulse or from a hardware trigger, depending on the trigger-select mode. The start is taken only while the enable input is high and the controller is armed. The controller then holds the sample/convert control high for a programmable sampling window. It drops the control low for a fixed conversion window and writes the converted value into one slot of a small result bank. The slot is chosen by the start address captured at the start.

A converter model stands in for the analog part. It captures the stimulus value at the end of sampling and counts a fixed number of conversion cycles before it returns that value. Writing a slot raises that slot's flag. The interrupt line is the OR of all flags that are also enabled. A flag stays set until an explicit clear or a read of its slot. If the enable input drops before the conversion finishes, the operation is abandoned with no write. Once a conversion completes, the controller is disarmed until the enable input has been low for at least one cycle. A change of trigger-select applies only between operations.

Top module: `adc_oneshot_seq`

## Requirements
- R1: After reset, busy_o, sample_conv_o, flag_o, irq_o and mode_o are all 0.
- R2: When idle, armed and enable_i is high, a start event makes busy_o and sample_conv_o high from the next cycle on. With mode_o=0 the start event is sw_start_i, and with mode_o=1 it is hw_trig_i. The input not selected is ignored. enable_i may rise in the same cycle as the start event.
- R3: sample_conv_o stays high for max(1, sample_cycles_i) cycles, taken at the start, and then stays low for 13 conversion cycles. busy_o is high for all of these cycles and low in the cycle after.
- R4: On completion, the slot given by start_addr_i at the start holds the value sample_data_i had in the last sampling cycle, and rd_data_o shows the slot selected by rd_addr_i.
- R5: If enable_i is low in any busy cycle, including the last conversion cycle, busy_o is low in the next cycle, and no slot or flag changes.
- R6: After a completed conversion, start events are ignored until enable_i has been low for at least one cycle.
- R7: A slot write sets that slot's bit in flag_o. irq_o is high exactly when some flag bit and the same bit of ie_i are both high.
- R8: A flag bit is cleared by the matching bit of flag_clr_i or by a cycle with rd_en_i high and rd_addr_i selecting that slot.
- R9: mode_o takes the value of mode_i one cycle later while idle. While busy, mode_o holds, and a value written during a conversion is applied after it completes.
- R10: The first start after reset needs no prior low phase of enable_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Enable-conversion level |
| sw_start_i | input | 1 | Software start event |
| hw_trig_i | input | 1 | Hardware trigger event |
| mode_i | input | 1 | Trigger select: 0 software, 1 hardware |
| start_addr_i | input | 4 | Destination slot for the result |
| sample_cycles_i | input | 8 | Sampling window length in cycles (0 acts as 1) |
| sample_data_i | input | 12 | Stimulus value returned by the converter model |
| ie_i | input | 16 | Per-slot interrupt enables |
| flag_clr_i | input | 16 | Per-slot flag clear |
| rd_en_i | input | 1 | Read strobe for the slot at rd_addr_i |
| rd_addr_i | input | 4 | Read slot select |
| rd_data_o | output | 12 | Content of the selected slot |
| sample_conv_o | output | 1 | High while sampling, low otherwise |
| busy_o | output | 1 | Operation in progress |
| mode_o | output | 1 | Trigger select currently applied |
| flag_o | output | 16 | Per-slot completion flags |
| irq_o | output | 1 | Interrupt request |

## Verification
A sweep over every slot, with sampling windows of 0 to 4 cycles, checks the phase timing cycle by cycle. Each slot gets a distinct value, and the stimulus changes once sampling ends. This separates a wrong slot index, an off-by-one window and a late data capture. A second group of tests drops enable at three points: in sampling, mid-conversion and on the final conversion cycle. These show that an abandoned operation leaves the slot value and flag untouched. Further tests hold enable high after a completion, switch the trigger source during a conversion, and pulse the trigger input that is not selected. These separate the disarm and the mode hold from plain start decoding.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SAMPLE  = 2'd1,
    ST_CONVERT = 2'd2
  } seq_state_e;

  localparam logic TRIG_SW = 1'b0;
  localparam logic TRIG_HW = 1'b1;
endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int SW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic          sw_start_i,
  input  logic          hw_trig_i,
  input  logic          mode_i,
  input  logic [SW-1:0] sample_cycles_i,
  input  logic          conv_done_i,
  output logic          start_o,
  output logic          conv_start_o,
  output logic          abort_o,
  output logic          wr_o,
  output logic          sample_conv_o,
  output logic          busy_o,
  output logic          mode_o
);
  seq_state_e    state_q, state_d;
  logic [SW-1:0] cnt_q;
  logic          lock_q;
  logic          mode_q;
  logic          start_evt;

  assign start_evt     = (mode_q == TRIG_HW) ? hw_trig_i : sw_start_i;
  assign start_o       = (state_q == ST_IDLE) && enable_i && !lock_q && start_evt;
  assign abort_o       = (state_q != ST_IDLE) && !enable_i;
  assign conv_start_o  = (state_q == ST_SAMPLE) && enable_i && (cnt_q == '0);
  assign wr_o          = (state_q == ST_CONVERT) && enable_i && conv_done_i;
  assign sample_conv_o = (state_q == ST_SAMPLE);
  assign busy_o        = (state_q != ST_IDLE);
  assign mode_o        = mode_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_o) state_d = ST_SAMPLE;
      ST_SAMPLE:  if (abort_o) state_d = ST_IDLE;
                  else if (conv_start_o) state_d = ST_CONVERT;
      ST_CONVERT: if (abort_o || wr_o) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      lock_q  <= 1'b0;
      mode_q  <= TRIG_SW;
    end else begin
      state_q <= state_d;
      if (start_o)
        cnt_q <= (sample_cycles_i == '0) ? '0 : sample_cycles_i - 1'b1;
      else if (state_q == ST_SAMPLE && cnt_q != '0)
        cnt_q <= cnt_q - 1'b1;
      // disarm after a completed result; re-arm once enable seen low
      if (wr_o) lock_q <= 1'b1;
      else if (!enable_i) lock_q <= 1'b0;
      if (state_q == ST_IDLE) mode_q <= mode_i;
    end
  end

  // R5
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && !enable_i) |=> (state_q == ST_IDLE));
  // R6
  lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && lock_q && enable_i) |=> (state_q == ST_IDLE));
  // R9
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> (mode_q == $past(mode_q)));
  // R3
  sample_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> (sample_conv_o && busy_o));
endmodule

// File: rtl/adc_conv_model.sv
module adc_conv_model #(
  parameter int DW          = 12,
  parameter int CONV_CYCLES = 13,
  localparam int CW = $clog2(CONV_CYCLES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic [DW-1:0] data_i,
  output logic          done_o,
  output logic [DW-1:0] result_o
);
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic [DW-1:0] hold_q;

  assign done_o   = run_q && (cnt_q == '0);
  assign result_o = hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      hold_q <= '0;
    end else if (start_i) begin
      cnt_q  <= CW'(CONV_CYCLES - 1);
      run_q  <= 1'b1;
      hold_q <= data_i;
    end else if (run_q) begin
      if (abort_i || cnt_q == '0) run_q <= 1'b0;
      else cnt_q <= cnt_q - 1'b1;
    end
  end

  // R3
  conv_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_o);
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int SLOTS = 16,
  parameter int DW    = 12,
  localparam int AW = $clog2(SLOTS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [SLOTS-1:0] clr_i,
  input  logic             rd_en_i,
  input  logic [AW-1:0]    rd_addr_i,
  input  logic [SLOTS-1:0] ie_i,
  output logic [DW-1:0]    rd_data_o,
  output logic [SLOTS-1:0] flag_o,
  output logic             irq_o
);
  logic [DW-1:0]    mem_q [SLOTS];
  logic [SLOTS-1:0] flag_q;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic hit_wr, hit_rd;
    assign hit_wr = wr_i && (wr_addr_i == AW'(g));
    assign hit_rd = rd_en_i && (rd_addr_i == AW'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[g]  <= '0;
        flag_q[g] <= 1'b0;
      end else begin
        if (hit_wr) mem_q[g] <= wr_data_i;
        // a new result outranks a clear in the same cycle
        if (hit_wr) flag_q[g] <= 1'b1;
        else if (clr_i[g] || hit_rd) flag_q[g] <= 1'b0;
      end
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
  assign flag_o    = flag_q;
  assign irq_o     = |(flag_q & ie_i);

  // R7
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> flag_o[$past(wr_addr_i)]);
  // R4
  wr_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (mem_q[$past(wr_addr_i)] == $past(wr_data_i)));
endmodule

// File: rtl/adc_oneshot_seq.sv
module adc_oneshot_seq
  import adc_seq_pkg::*;
#(
  parameter int SLOTS       = 16,
  parameter int DW          = 12,
  parameter int SW          = 8,
  parameter int CONV_CYCLES = 13,
  localparam int AW = $clog2(SLOTS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             sw_start_i,
  input  logic             hw_trig_i,
  input  logic             mode_i,
  input  logic [AW-1:0]    start_addr_i,
  input  logic [SW-1:0]    sample_cycles_i,
  input  logic [DW-1:0]    sample_data_i,
  input  logic [SLOTS-1:0] ie_i,
  input  logic [SLOTS-1:0] flag_clr_i,
  input  logic             rd_en_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [DW-1:0]    rd_data_o,
  output logic             sample_conv_o,
  output logic             busy_o,
  output logic             mode_o,
  output logic [SLOTS-1:0] flag_o,
  output logic             irq_o
);
  logic          start, conv_start, abort, wr, conv_done;
  logic [DW-1:0] conv_result;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else if (start) addr_q <= start_addr_i;
  end

  adc_seq_ctrl #(.SW(SW)) u_ctrl (
    .clk_i, .rst_ni, .enable_i, .sw_start_i, .hw_trig_i, .mode_i, .sample_cycles_i,
    .conv_done_i   (conv_done),
    .start_o       (start),
    .conv_start_o  (conv_start),
    .abort_o       (abort),
    .wr_o          (wr),
    .sample_conv_o,
    .busy_o,
    .mode_o
  );

  adc_conv_model #(.DW(DW), .CONV_CYCLES(CONV_CYCLES)) u_conv (
    .clk_i, .rst_ni,
    .start_i  (conv_start),
    .abort_i  (abort),
    .data_i   (sample_data_i),
    .done_o   (conv_done),
    .result_o (conv_result)
  );

  adc_result_bank #(.SLOTS(SLOTS), .DW(DW)) u_bank (
    .clk_i, .rst_ni,
    .wr_i      (wr),
    .wr_addr_i (addr_q),
    .wr_data_i (conv_result),
    .clr_i     (flag_clr_i),
    .rd_en_i, .rd_addr_i, .ie_i, .rd_data_o, .flag_o, .irq_o
  );

  // R1
  idle_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sample_conv_o);
endmodule

// File: tb/adc_oneshot_seq_tb.sv
module adc_oneshot_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CONV = 13;

  logic        clk = 0, rst_n = 0;
  logic        enable = 0, sw_start = 0, hw_trig = 0, mode = 0, rd_en = 0;
  logic [3:0]  start_addr = 0, rd_addr = 0;
  logic [7:0]  scyc = 0;
  logic [11:0] sdata = 0, rd_data;
  logic [15:0] ie = 0, fclr = 0, flag;
  logic        sc, busy, mode_o, irq;
  logic [11:0] exp_mem [16];
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_oneshot_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .sw_start_i(sw_start),
    .hw_trig_i(hw_trig), .mode_i(mode), .start_addr_i(start_addr),
    .sample_cycles_i(scyc), .sample_data_i(sdata), .ie_i(ie), .flag_clr_i(fclr),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .sample_conv_o(sc), .busy_o(busy), .mode_o(mode_o), .flag_o(flag), .irq_o(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic rearm();
    enable = 0; tick();
  endtask

  // full conversion; mode_next is driven during conversion
  task automatic do_conv(input int addr, input int n, input logic [11:0] d,
                         input bit hw, input bit mode_next, input bit do_read);
    int neff, bad;
    bit m0;
    neff = (n == 0) ? 1 : n;
    m0 = mode_o;
    start_addr = 4'(addr); scyc = 8'(n); sdata = d; enable = 1;
    if (hw) hw_trig = 1; else sw_start = 1;
    tick();
    sw_start = 0; hw_trig = 0;
    start_addr = 4'(addr + 1);
    bad = 0;
    for (int i = 0; i < neff; i++) begin
      if (!(busy && sc)) bad++;
      tick();
    end
    check(bad == 0, "R3 sampling window", bad, 0);
    sdata = ~d;
    mode = mode_next;
    bad = 0;
    for (int i = 0; i < CONV; i++) begin
      if (!(busy && !sc)) bad++;
      tick();
    end
    check(bad == 0, "R3 conversion window", bad, 0);
    check(!busy, "R3 busy low after end", busy, 0);
    check(mode_o == m0, "R9 mode held during conversion", mode_o, m0);
    exp_mem[addr] = d;
    check(flag[addr], "R7 flag set", flag[addr], 1);
    check(irq == ie[addr], "R7 irq", irq, ie[addr]);
    rd_addr = 4'(addr);
    #1;
    check(rd_data == d, "R4 slot data", rd_data, d);
    if (do_read) begin
      rd_en = 1; tick(); rd_en = 0;
      check(!flag[addr], "R8 flag cleared by read", flag[addr], 0);
    end
  endtask

  task automatic abort_at(input int addr, input int n, input int after);
    start_addr = 4'(addr); scyc = 8'(n); sdata = 12'hABC; enable = 1; sw_start = 1;
    tick(); sw_start = 0;
    repeat (after) tick();
    check(busy, "R5 busy before abort", busy, 1);
    enable = 0; tick();
    check(!busy, "R5 busy drops", busy, 0);
    repeat (CONV + 4) tick();
    rd_addr = 4'(addr); #1;
    check(!flag[addr], "R5 no flag", flag[addr], 0);
    check(rd_data == exp_mem[addr], "R5 slot unchanged", rd_data, exp_mem[addr]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) exp_mem[i] = '0;
    @(negedge clk); @(negedge clk);
    check(!busy && !sc && flag == 0 && !irq && !mode_o, "R1 reset state", busy, 0);
    rst_n = 1; tick();
    ie = 16'h00FF;
    // R10: first start right after reset, enable rising with start
    do_conv(0, 0, 12'(5), 0, 0, 1);
    check(!busy, "R10 first start accepted", 0, 0);
    for (int a = 1; a < 16; a++) begin
      rearm();
      do_conv(a, a % 5, 12'((a * 37 + 5) & 12'hFFF), 0, 0, 1);
    end
    // R6: enable still high, starts ignored
    sw_start = 1; tick(); sw_start = 0; tick();
    check(!busy, "R6 start ignored while disarmed", busy, 1);
    rearm();
    // R2: unselected trigger ignored in software mode
    enable = 1; hw_trig = 1; tick(); hw_trig = 0; tick();
    check(!busy, "R2 hw trigger ignored in sw mode", busy, 1);
    // R5: abort in sampling, mid-conversion and on last conversion cycle
    abort_at(5, 3, 1);
    abort_at(6, 2, 2 + 5);
    abort_at(7, 1, 1 + CONV - 1);
    // R9: mode applies one cycle later while idle
    mode = 1; tick();
    check(mode_o == 1, "R9 mode applied while idle", mode_o, 1);
    enable = 1; sw_start = 1; tick(); sw_start = 0; tick();
    check(!busy, "R2 sw start ignored in hw mode", busy, 1);
    rearm();
    do_conv(9, 2, 12'h5A5, 1, 0, 1);
    check(mode_o == 0, "R9 new mode after completion", mode_o, 0);
    // R8: explicit clear, with irq on an enabled slot
    rearm();
    do_conv(2, 1, 12'h123, 0, 0, 0);
    check(irq, "R7 irq with enabled flag", irq, 1);
    fclr = 16'h0004; tick(); fclr = 0;
    check(!flag[2] && !irq, "R8 flag cleared by clear input", flag[2], 0);
    // R7: disabled slot raises flag but no irq
    rearm();
    do_conv(12, 0, 12'h0F0, 0, 0, 0);
    check(!irq && flag[12], "R7 no irq for disabled slot", irq, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule